// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block holds the time of day and the calendar date in seven packed-BCD byte registers. A one-cycle 1 Hz enable from an external divider moves the time forward by one second. Each field carries into the next: seconds into minutes, minutes into hours, hours into the day. The day carry advances the date and the weekday together. The date wraps at the true length of the current month, and February gets its 29th day in every year divisible by four.

The hours register is shared between two formats, chosen at run time by its top bit. In the 12-hour format bit 5 is the afternoon flag. In the 24-hour format the same bit is the tens-of-twenty digit. Bit 7 of the seconds register is a halt flag that freezes all counting while set. An external controller writes any register through a parallel load port and reads any register through a parallel read port. Register indices are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 weekday and 6 year. Index 7 holds nothing.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: Each `tick_1hz` pulse, when there is no write and the halt flag is 0, adds one to seconds. Seconds and minutes wrap from 0x59 to 0x00 and carry into the next field. With no tick and no write, no register changes.
- R2: While seconds bit 7 (halt) is 1, ticks change no register and the halt bit stays set. Writing bit 7 as 0 resumes counting on the next tick.
- R3: Hours bit 7 selects the format (1 = 12-hour, 0 = 24-hour). Counting never changes this bit.
- R4: In the 24-hour format, hours count 0x00 to 0x23. The step from 0x23 to 0x00 raises the day carry.
- R5: In the 12-hour format, bits 4:0 hold BCD 01..12 and bit 5 is PM (1 = PM). Hours step 12, 01, ..., 11, 12. The step from 11 to 12 inverts bit 5. Only the step from 11 PM to 12 AM raises the day carry.
- R6: On a day carry, the date goes to 0x01 and the month advances once the date has reached the month's length. The length is 31 days, or 30 days for months 04, 06, 09 and 11. Otherwise the date steps up by one.
- R7: February has 29 days when the BCD year value 00..99 is divisible by four, including 00. In every other year it has 28.
- R8: The weekday counts 1..7 and advances on each day carry, wrapping from 7 to 1.
- R9: The month wraps from 0x12 to 0x01 and carries into the year. The year wraps from 0x99 to 0x00.
- R10: A load-port write to indices 0..6 stores the byte exactly. If a tick arrives in the same cycle as a write, the tick is discarded: no field advances and no carry is raised. A write to index 7 changes nothing and index 7 reads 0x00.
- R11: After reset, the registers read seconds 0x00, minutes 0x00, hours 0x00 (24-hour format), date 0x01, month 0x01, weekday 0x01 and year 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse that advances time by one second |
| wr_en | input | 1 | Load-port write strobe |
| wr_addr | input | 3 | Register index for the write |
| wr_data | input | 8 | Byte to store |
| rd_addr | input | 3 | Register index for the read |
| rd_data | output | 8 | Register contents, combinational by default |

## Verification
The bench sweeps every hour in both formats, both halves of the day, and every second and minute value. Each sweep runs into a carry, which catches a design that toggles PM on the wrong step or raises the day carry at noon. Every month is driven from its last day and its second-to-last day, and every year 00..99 is driven from 28 February. A wrong length table or a century-style leap rule would wrap the date too early or too late. Further checks cover a frozen clock under repeated ticks and a write colliding with a tick at 59 seconds. A design that let the tick slip through there would corrupt the written byte or bump the minutes.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   typedef enum logic [2:0] {
      F_SEC  = 3'd0,
      F_MIN  = 3'd1,
      F_HOUR = 3'd2,
      F_DATE = 3'd3,
      F_MON  = 3'd4,
      F_DOW  = 3'd5,
      F_YEAR = 3'd6
   } field_e;

   localparam int unsigned NUM_FIELDS = 7;

   function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
      return 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
   endfunction

   function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
      return {4'(v / 7'd10), 4'(v % 7'd10)};
   endfunction

endpackage

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap
   import rtc_cal_pkg::*;
#(
   parameter int unsigned LO = 0,
   parameter int unsigned HI = 59
) (
   input  logic [7:0] cur,
   output logic [7:0] nxt,
   output logic       wrap
);

   if (HI > 99 || LO >= HI) begin : g_bad_range
      $error("rtc_bcd_wrap: range must satisfy LO < HI <= 99");
   end

   logic [7:0] val;

   always_comb begin
      val = bcd_to_bin(cur);
      if (val >= 8'(HI)) begin
         nxt  = bin_to_bcd(7'(LO));
         wrap = 1'b1;
      end else begin
         nxt  = bin_to_bcd(7'(val + 8'd1));
         wrap = 1'b0;
      end
   end

endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
   import rtc_cal_pkg::*;
(
   input  logic       mode_12,
   input  logic [5:0] hbits,
   output logic [7:0] hour_nxt,
   output logic       day_carry
);

   logic [7:0] h12;
   logic [7:0] h24;

   always_comb begin
      h12       = bcd_to_bin({3'b000, hbits[4:0]});
      h24       = bcd_to_bin({2'b00, hbits});
      day_carry = 1'b0;
      if (mode_12) begin
         if (h12 >= 8'd12) begin
            hour_nxt = {1'b1, 1'b0, hbits[5], 5'h01};
         end else if (h12 == 8'd11) begin
            hour_nxt  = {1'b1, 1'b0, ~hbits[5], 5'h12};
            day_carry = hbits[5];
         end else begin
            hour_nxt = {1'b1, 1'b0, hbits[5], 5'b0} | bin_to_bcd(7'(h12 + 8'd1));
         end
      end else begin
         if (h24 >= 8'd23) begin
            hour_nxt  = 8'h00;
            day_carry = 1'b1;
         end else begin
            hour_nxt = bin_to_bcd(7'(h24 + 8'd1));
         end
      end
   end

endmodule

// File: rtl/rtc_date_step.sv
module rtc_date_step
   import rtc_cal_pkg::*;
(
   input  logic [7:0] date_cur,
   input  logic [7:0] mon_cur,
   input  logic [7:0] yr_cur,
   output logic [7:0] date_nxt,
   output logic       mon_carry
);

   logic [7:0] d_bin;
   logic [7:0] m_bin;
   logic [7:0] y_bin;
   logic [7:0] last_day;
   logic       leap;

   always_comb begin
      d_bin = bcd_to_bin(date_cur);
      m_bin = bcd_to_bin(mon_cur);
      y_bin = bcd_to_bin(yr_cur);
      leap  = (y_bin % 8'd4) == 8'd0;
      case (m_bin)
         8'd2:                    last_day = leap ? 8'd29 : 8'd28;
         8'd4, 8'd6, 8'd9, 8'd11: last_day = 8'd30;
         default:                 last_day = 8'd31;
      endcase
      if (d_bin >= last_day) begin
         date_nxt  = 8'h01;
         mon_carry = 1'b1;
      end else begin
         date_nxt  = bin_to_bcd(7'(d_bin + 8'd1));
         mon_carry = 1'b0;
      end
   end

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
   import rtc_cal_pkg::*;
#(
   parameter int unsigned FIELD_W  = 8,
   parameter int unsigned ADDR_W   = 3,
   parameter bit          RD_REG   = 1'b0,
   parameter logic [7:0]  RST_SEC  = 8'h00,
   parameter logic [7:0]  RST_MIN  = 8'h00,
   parameter logic [7:0]  RST_HOUR = 8'h00,
   parameter logic [7:0]  RST_DATE = 8'h01,
   parameter logic [7:0]  RST_MON  = 8'h01,
   parameter logic [7:0]  RST_DOW  = 8'h01,
   parameter logic [7:0]  RST_YEAR = 8'h00
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_1hz,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [FIELD_W-1:0] wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [FIELD_W-1:0] rd_data
);

   if (FIELD_W != 8) begin : g_bad_width
      $error("rtc_bcd_calendar: packed BCD fields need FIELD_W == 8");
   end
   if ((1 << ADDR_W) < NUM_FIELDS) begin : g_bad_addr
      $error("rtc_bcd_calendar: ADDR_W too small for all fields");
   end

   // Simple wrapping counters: seconds, minutes, month, weekday, year
   localparam int unsigned NCNT = 5;
   localparam int unsigned CNT_LO [NCNT] = '{0, 0, 1, 1, 0};
   localparam int unsigned CNT_HI [NCNT] = '{59, 59, 12, 7, 99};
   localparam int unsigned C_SEC = 0, C_MIN = 1, C_MON = 2, C_DOW = 3, C_YR = 4;

   logic [FIELD_W-1:0] sec_q, min_q, hour_q, date_q, mon_q, dow_q, yr_q;

   logic [7:0] cnt_in   [NCNT];
   logic [7:0] cnt_nxt  [NCNT];
   logic       cnt_wrap [NCNT];

   assign cnt_in[C_SEC] = {1'b0, sec_q[6:0]};
   assign cnt_in[C_MIN] = min_q;
   assign cnt_in[C_MON] = mon_q;
   assign cnt_in[C_DOW] = dow_q;
   assign cnt_in[C_YR]  = yr_q;

   for (genvar g = 0; g < NCNT; g++) begin : g_cnt
      rtc_bcd_wrap #(
         .LO(CNT_LO[g]),
         .HI(CNT_HI[g])
      ) u_wrap (
         .cur (cnt_in[g]),
         .nxt (cnt_nxt[g]),
         .wrap(cnt_wrap[g])
      );
   end

   logic unused_wraps;
   assign unused_wraps = cnt_wrap[C_DOW] ^ cnt_wrap[C_YR];

   logic [7:0] hour_nxt;
   logic       day_carry;

   rtc_hour_step u_hour (
      .mode_12  (hour_q[7]),
      .hbits    (hour_q[5:0]),
      .hour_nxt (hour_nxt),
      .day_carry(day_carry)
   );

   logic [7:0] date_nxt;
   logic       mon_carry;

   rtc_date_step u_date (
      .date_cur (date_q),
      .mon_cur  (mon_q),
      .yr_cur   (yr_q),
      .date_nxt (date_nxt),
      .mon_carry(mon_carry)
   );

   logic advance;
   assign advance = tick_1hz && !wr_en && !sec_q[7];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q  <= RST_SEC;
         min_q  <= RST_MIN;
         hour_q <= RST_HOUR;
         date_q <= RST_DATE;
         mon_q  <= RST_MON;
         dow_q  <= RST_DOW;
         yr_q   <= RST_YEAR;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_W'(F_SEC):  sec_q  <= wr_data;
            ADDR_W'(F_MIN):  min_q  <= wr_data;
            ADDR_W'(F_HOUR): hour_q <= wr_data;
            ADDR_W'(F_DATE): date_q <= wr_data;
            ADDR_W'(F_MON):  mon_q  <= wr_data;
            ADDR_W'(F_DOW):  dow_q  <= wr_data;
            ADDR_W'(F_YEAR): yr_q   <= wr_data;
            default: ;
         endcase
      end else if (advance) begin
         sec_q <= cnt_nxt[C_SEC];
         if (cnt_wrap[C_SEC]) begin
            min_q <= cnt_nxt[C_MIN];
            if (cnt_wrap[C_MIN]) begin
               hour_q <= hour_nxt;
               if (day_carry) begin
                  dow_q  <= cnt_nxt[C_DOW];
                  date_q <= date_nxt;
                  if (mon_carry) begin
                     mon_q <= cnt_nxt[C_MON];
                     if (cnt_wrap[C_MON]) begin
                        yr_q <= cnt_nxt[C_YR];
                     end
                  end
               end
            end
         end
      end
   end

   logic [FIELD_W-1:0] rd_mux;

   always_comb begin
      case (rd_addr)
         ADDR_W'(F_SEC):  rd_mux = sec_q;
         ADDR_W'(F_MIN):  rd_mux = min_q;
         ADDR_W'(F_HOUR): rd_mux = hour_q;
         ADDR_W'(F_DATE): rd_mux = date_q;
         ADDR_W'(F_MON):  rd_mux = mon_q;
         ADDR_W'(F_DOW):  rd_mux = dow_q;
         ADDR_W'(F_YEAR): rd_mux = yr_q;
         default:         rd_mux = '0;
      endcase
   end

   if (RD_REG) begin : g_rd_reg
      logic [FIELD_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_mux;
      end
      assign rd_data = rd_q;
   end else begin : g_rd_comb
      assign rd_data = rd_mux;
   end

endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_1hz,
   input logic       wr_en,
   input logic [2:0] wr_addr,
   input logic [7:0] wr_data,
   input logic [7:0] sec,
   input logic [7:0] min,
   input logic [7:0] hour,
   input logic [7:0] date,
   input logic [7:0] mon,
   input logic [7:0] dow,
   input logic [7:0] yr
);

   logic       w_q;
   logic [2:0] a_q;
   logic [7:0] d_q;
   logic [7:0] sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_q <= 1'b0;
         a_q <= '0;
         d_q <= '0;
      end else begin
         w_q <= wr_en;
         a_q <= wr_addr;
         d_q <= wr_data;
      end
   end

   always_comb begin
      case (a_q)
         3'd0:    sel = sec;
         3'd1:    sel = min;
         3'd2:    sel = hour;
         3'd3:    sel = date;
         3'd4:    sel = mon;
         3'd5:    sel = dow;
         3'd6:    sel = yr;
         default: sel = 8'h00;
      endcase
   end

   assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (w_q && a_q != 3'd7) |-> sel == d_q);

   assert_halt_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && sec[7]) |=> ($stable(sec) && $stable(min) && $stable(hour) && $stable(date)));

   assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !tick_1hz) |=> $stable({sec, min, hour, date, mon, dow, yr}));

   assert_early_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && !wr_en && !sec[7] && sec[6:0] < 7'h59) |=> ($stable(min) && sec != $past(sec)));

   assert_mode_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == 3'd2) |=> hour[7] == $past(hour[7]));

   assert_midnight_dow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && !wr_en && sec == 8'h59 && min == 8'h59 && hour == 8'h23)
      |=> (dow != $past(dow) && hour == 8'h00));

endmodule

bind rtc_bcd_calendar rtc_cal_checker u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick_1hz(tick_1hz),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .sec     (sec_q),
   .min     (min_q),
   .hour    (hour_q),
   .date    (date_q),
   .mon     (mon_q),
   .dow     (dow_q),
   .yr      (yr_q)
);

// File: tb/rtc_bcd_calendar_tb.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rtc_bcd_calendar u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_1hz(tick),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   function automatic logic [7:0] bcd(input int v);
      return 8'((v / 10) * 16 + (v % 10));
   endfunction

   function automatic int mdays(input int m, input int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
      rd_addr = a;
      #1;
      n_chk++;
      if (rd_data !== exp) begin
         n_fail++;
         $display("FAIL %s reg %0d: actual %h expected %h", tag, a, rd_data, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick1();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic set_all(input logic [7:0] s, m, h, d, mo, dw, y);
      wr(0, s); wr(1, m); wr(2, h); wr(3, d); wr(4, mo); wr(5, dw); wr(6, y);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset values
      chk(0, 8'h00, "R11"); chk(1, 8'h00, "R11"); chk(2, 8'h00, "R11");
      chk(3, 8'h01, "R11"); chk(4, 8'h01, "R11"); chk(5, 8'h01, "R11");
      chk(6, 8'h00, "R11"); chk(7, 8'h00, "R11");

      // R1 no tick, no change
      repeat (5) @(negedge clk);
      chk(0, 8'h00, "R1 idle");

      // R1 seconds sweep
      for (int s = 0; s < 60; s++) begin
         wr(0, bcd(s)); wr(1, 8'h10);
         tick1();
         chk(0, bcd((s + 1) % 60), "R1 sec");
         chk(1, (s == 59) ? 8'h11 : 8'h10, "R1 sec carry");
      end

      // R1 minutes sweep
      for (int m = 0; m < 60; m++) begin
         wr(0, 8'h59); wr(1, bcd(m)); wr(2, 8'h05);
         tick1();
         chk(1, bcd((m + 1) % 60), "R1 min");
         chk(2, (m == 59) ? 8'h06 : 8'h05, "R1 min carry");
      end

      // R4 24-hour sweep, R8 weekday
      for (int h = 0; h < 24; h++) begin
         set_all(8'h59, 8'h59, bcd(h), 8'h15, 8'h06, 8'h03, 8'h21);
         tick1();
         chk(2, bcd((h + 1) % 24), "R4 hour");
         chk(3, (h == 23) ? 8'h16 : 8'h15, "R4 day carry");
         chk(5, (h == 23) ? 8'h04 : 8'h03, "R8 dow");
      end

      // R5 12-hour sweep, R3 mode kept
      for (int pm = 0; pm < 2; pm++) begin
         for (int h = 1; h <= 12; h++) begin
            logic [7:0] eh;
            int nh;
            int npm;
            set_all(8'h59, 8'h59, 8'h80 | 8'(pm << 5) | bcd(h), 8'h15, 8'h06, 8'h03, 8'h21);
            tick1();
            nh  = (h == 12) ? 1 : h + 1;
            npm = (h == 11) ? 1 - pm : pm;
            eh  = 8'h80 | 8'(npm << 5) | bcd(nh);
            chk(2, eh, "R5 R3 12h hour");
            chk(3, (h == 11 && pm == 1) ? 8'h16 : 8'h15, "R5 day carry");
         end
      end

      // R8 weekday wrap across all values
      for (int d = 1; d <= 7; d++) begin
         set_all(8'h59, 8'h59, 8'h23, 8'h10, 8'h03, bcd(d), 8'h05);
         tick1();
         chk(5, bcd(d % 7 + 1), "R8 dow wrap");
      end

      // R6 R9 month lengths in a common year
      for (int m = 1; m <= 12; m++) begin
         int ld;
         ld = mdays(m, 1);
         set_all(8'h59, 8'h59, 8'h23, bcd(ld - 1), bcd(m), 8'h02, 8'h01);
         tick1();
         chk(3, bcd(ld), "R6 before last");
         chk(4, bcd(m), "R6 month hold");
         set_all(8'h59, 8'h59, 8'h23, bcd(ld), bcd(m), 8'h02, 8'h01);
         tick1();
         chk(3, 8'h01, "R6 date wrap");
         chk(4, bcd(m % 12 + 1), "R6 R9 month");
         chk(6, (m == 12) ? 8'h02 : 8'h01, "R9 year carry");
      end

      // R7 February in every year
      for (int y = 0; y < 100; y++) begin
         set_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h01, bcd(y));
         tick1();
         chk(3, (y % 4 == 0) ? 8'h29 : 8'h01, "R7 feb date");
         chk(4, (y % 4 == 0) ? 8'h02 : 8'h03, "R7 feb month");
      end

      // R9 year wrap
      set_all(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h07, 8'h99);
      tick1();
      chk(6, 8'h00, "R9 year wrap");
      chk(4, 8'h01, "R9 month wrap");
      chk(3, 8'h01, "R9 date");
      chk(5, 8'h01, "R9 R8 dow");

      // R2 halt
      set_all(8'h90, 8'h20, 8'h08, 8'h05, 8'h05, 8'h02, 8'h10);
      repeat (3) tick1();
      chk(0, 8'h90, "R2 halted sec");
      chk(1, 8'h20, "R2 halted min");
      wr(0, 8'h10);
      tick1();
      chk(0, 8'h11, "R2 restart");

      // R10 write collides with tick at 59 seconds
      wr(0, 8'h59); wr(1, 8'h10);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h30; tick = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; tick = 1'b0;
      chk(0, 8'h30, "R10 write wins");
      chk(1, 8'h10, "R10 no carry");

      // R10 index 7 ignored
      wr(7, 8'hFF);
      chk(7, 8'h00, "R10 idx7");
      chk(0, 8'h30, "R10 idx7 sec");
      chk(6, 8'h10, "R10 idx7 year");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule